// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps time of day and calendar as a chain of packed-BCD counters. It holds hundredths of seconds, seconds, minutes, hours, day of week, date, month and two-digit year. A 100 Hz tick enable steps the hundredths. Each field carries into the next one when it wraps. The date rolls over at the true length of the month, and February is corrected for leap years.

Software reaches every field through one register write port and one read port, both addressed by a 3-bit field select. The hours field also holds a format bit that picks 12-hour or 24-hour counting, and an AM/PM flag that the counter keeps itself.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read: hundredths 00, seconds 00, minutes 00, hours 00 in 24-hour format, day of week 01, date 01, month 01, year 00.
- R2: Each clock with `tick_i` high and no write advances the hundredths by one. Hundredths roll 99 to 00, and seconds and minutes roll 59 to 00. Each roll carries one into the next field.
- R3: Field selects are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A write loads the selected field at the next clock edge. Every write, including a write to select 0, sets hundredths to 00. A write cycle takes precedence over a tick in the same cycle.
- R4: The hours field has bit 6 = 0 for 24-hour format, with the hour in bits 5:0. In this format the hour counts 00 to 23, and 23 to 00 advances the date and day of week.
- R5: The hours field has bit 6 = 1 for 12-hour format, with bit 5 = PM and the hour in bits 4:0. The hour runs 12, 01, ..., 11, 12. The PM bit flips on 11 to 12. The date advances only when 11 PM becomes 12 AM.
- R6: The date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each date roll increments the month.
- R7: February rolls after 29 when the year is divisible by 4 (00 included), otherwise after 28.
- R8: Day of week counts 01 to 07 and wraps 07 to 01. It steps only at the midnight carry.
- R9: Month 12 rolls to 01 and increments the year. Year 99 rolls to 00.
- R10: With no tick and no write, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz step enable, one clock wide per step |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for write |
| wr_data_i | input | 8 | BCD write data |
| rd_sel_i | input | 3 | Field select for read |
| rd_data_o | output | 8 | BCD value of selected field |

## Verification
The hardest cases to reach from the ports are the calendar corners: month ends, February in leap and common years, year 99 at the last day of December, and 11 PM in 12-hour mode. Reaching any of them from reset would take millions of ticks. The stimulus instead writes the hour, date, month, year and day fields, then writes minutes and seconds to 59. That last write clears hundredths, so exactly 100 ticks cross the boundary. A table of such vectors covers each corner, and the bench compares every calendar field afterwards.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned NFIELD  = 8;
  localparam int unsigned SEL_W   = $clog2(NFIELD);

  localparam int unsigned FLD_HUND = 0;
  localparam int unsigned FLD_SEC  = 1;
  localparam int unsigned FLD_MIN  = 2;
  localparam int unsigned FLD_HOUR = 3;
  localparam int unsigned FLD_DOW  = 4;
  localparam int unsigned FLD_DATE = 5;
  localparam int unsigned FLD_MON  = 6;
  localparam int unsigned FLD_YEAR = 7;

  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [FIELD_W-1:0] fld_lo(input int unsigned f);
    fld_lo = (f == FLD_DOW || f == FLD_DATE || f == FLD_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [FIELD_W-1:0] fld_hi(input int unsigned f);
    case (f)
      FLD_SEC, FLD_MIN: fld_hi = 8'h59;
      FLD_DOW:          fld_hi = 8'h07;
      FLD_DATE:         fld_hi = 8'h31;
      FLD_MON:          fld_hi = 8'h12;
      default:          fld_hi = 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [FIELD_W-1:0] month_i,
  input  logic [FIELD_W-1:0] year_i,
  output logic [FIELD_W-1:0] last_date_o
);
  logic [1:0] mod4;
  logic       leap;

  // (10t + u) mod 4 == (2t + u) mod 4
  assign mod4 = {year_i[4], 1'b0} + year_i[1:0];
  assign leap = (mod4 == 2'd0);

  always_comb begin
    case (month_i)
      8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt
  import rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] LO = 8'h00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_val_i,
  input  logic [FIELD_W-1:0] hi_i,
  output logic [FIELD_W-1:0] val_o,
  output logic               wrap_o
);
  logic [FIELD_W-1:0] val_q;
  logic               at_top;

  assign at_top = (val_q >= hi_i);
  assign wrap_o = inc_i & at_top;
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= LO;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= at_top ? LO : bcd_inc(val_q);
  end

  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && (val_q >= hi_i) |=> val_q == LO);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !load_i |=> $stable(val_q));
endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_val_i,
  output logic [FIELD_W-1:0] val_o,
  output logic               day_o
);
  logic [FIELD_W-1:0] hr_q, hr_d;
  logic               mode12, pm;
  logic               midnight;

  assign mode12 = hr_q[6];
  assign pm     = hr_q[5];

  always_comb begin
    hr_d     = hr_q;
    midnight = 1'b0;
    if (!mode12) begin
      if (hr_q[5:0] >= 6'h23) begin
        hr_d     = 8'h00;
        midnight = 1'b1;
      end else begin
        hr_d = {2'b00, bcd_inc({2'b00, hr_q[5:0]})[5:0]};
      end
    end else begin
      if (hr_q[4:0] >= 5'h12) begin
        hr_d = {2'b01, pm, 5'h01};
      end else if (hr_q[4:0] == 5'h11) begin
        hr_d     = {2'b01, ~pm, 5'h12};
        midnight = pm;
      end else begin
        hr_d = {2'b01, pm, bcd_inc({3'b000, hr_q[4:0]})[4:0]};
      end
    end
  end

  assign day_o = inc_i & midnight;
  assign val_o = hr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hr_q <= '0;
    else if (load_i) hr_q <= {1'b0, load_val_i[6:0]};
    else if (inc_i)  hr_q <= hr_d;
  end

  // R5
  pm_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && hr_q[6] && hr_q[4:0] == 5'h11 |=> hr_q[5] != $past(hr_q[5]));

  // R4
  h24_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && !hr_q[6] && hr_q[5:0] == 6'h23 |=> hr_q == 8'h00);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [FIELD_W-1:0] rd_data_o
);
  logic [FIELD_W-1:0] vals [NFIELD];
  logic [NFIELD-1:0]  inc, wrap, load;
  logic [FIELD_W-1:0] last_date;

  // write wins over tick
  assign inc[FLD_HUND] = tick_i & ~wr_en_i;
  assign inc[FLD_SEC]  = wrap[FLD_HUND];
  assign inc[FLD_MIN]  = wrap[FLD_SEC];
  assign inc[FLD_HOUR] = wrap[FLD_MIN];
  assign inc[FLD_DOW]  = wrap[FLD_HOUR];
  assign inc[FLD_DATE] = wrap[FLD_HOUR];
  assign inc[FLD_MON]  = wrap[FLD_DATE];
  assign inc[FLD_YEAR] = wrap[FLD_MON];

  rtc_month_len u_mlen (
    .month_i    (vals[FLD_MON]),
    .year_i     (vals[FLD_YEAR]),
    .last_date_o(last_date)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    if (g == FLD_HUND) begin : g_hund
      assign load[g] = wr_en_i;
    end else begin : g_other
      assign load[g] = wr_en_i && (wr_sel_i == SEL_W'(g));
    end

    if (g == FLD_HOUR) begin : g_hour
      rtc_hour_cnt u_hour (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (inc[g]),
        .load_i    (load[g]),
        .load_val_i(wr_data_i),
        .val_o     (vals[g]),
        .day_o     (wrap[g])
      );
    end else begin : g_cnt
      logic [FIELD_W-1:0] hi, ld_val;
      assign hi     = (g == FLD_DATE) ? last_date : fld_hi(g);
      assign ld_val = (g == FLD_HUND) ? '0 : wr_data_i;
      rtc_bcd_cnt #(.LO(fld_lo(g))) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (inc[g]),
        .load_i    (load[g]),
        .load_val_i(ld_val),
        .hi_i      (hi),
        .val_o     (vals[g]),
        .wrap_o    (wrap[g])
      );
    end
  end

  assign rd_data_o = vals[rd_sel_i];

  // R3
  wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vals[FLD_HUND] == 8'h00);

  // R8
  dow_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[FLD_DOW] |-> wrap[FLD_HOUR]);

  // R6
  mon_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[FLD_DATE] && !wr_en_i |=> vals[FLD_DATE] == 8'h01);
endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rtc_calendar_core u_rtc_calendar_core (.*);

  always #2 clk_i = ~clk_i;

  typedef struct packed {
    logic [7:0] hr, dt, mo, yr, dw;
    logic [7:0] hr_x, dt_x, mo_x, yr_x, dw_x;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{8'h23, 8'h31, 8'h01, 8'h24, 8'h03, 8'h00, 8'h01, 8'h02, 8'h24, 8'h04}, // R4 R6
    '{8'h23, 8'h30, 8'h04, 8'h23, 8'h07, 8'h00, 8'h01, 8'h05, 8'h23, 8'h01}, // R6 R8
    '{8'h23, 8'h28, 8'h02, 8'h23, 8'h01, 8'h00, 8'h01, 8'h03, 8'h23, 8'h02}, // R7
    '{8'h23, 8'h28, 8'h02, 8'h24, 8'h01, 8'h00, 8'h29, 8'h02, 8'h24, 8'h02}, // R7
    '{8'h23, 8'h29, 8'h02, 8'h00, 8'h02, 8'h00, 8'h01, 8'h03, 8'h00, 8'h03}, // R7
    '{8'h23, 8'h28, 8'h02, 8'h00, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, 8'h03}, // R7
    '{8'h23, 8'h31, 8'h12, 8'h99, 8'h05, 8'h00, 8'h01, 8'h01, 8'h00, 8'h06}, // R9
    '{8'h71, 8'h30, 8'h06, 8'h10, 8'h02, 8'h52, 8'h01, 8'h07, 8'h10, 8'h03}, // R5
    '{8'h51, 8'h15, 8'h08, 8'h10, 8'h04, 8'h72, 8'h15, 8'h08, 8'h10, 8'h04}, // R5
    '{8'h22, 8'h15, 8'h08, 8'h10, 8'h04, 8'h23, 8'h15, 8'h08, 8'h10, 8'h04}, // R4
    '{8'h72, 8'h15, 8'h08, 8'h10, 8'h04, 8'h61, 8'h15, 8'h08, 8'h10, 8'h04}, // R5
    '{8'h23, 8'h30, 8'h11, 8'h05, 8'h06, 8'h00, 8'h01, 8'h12, 8'h05, 8'h07}  // R6 R8
  };

  task automatic check(input string req, input logic [2:0] sel, input logic [7:0] exp);
    @(negedge clk_i);
    rd_sel_i = sel;
    #1;
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s field %0d: got %h expected %h", req, sel, rd_data_o, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1", 3'd0, 8'h00); check("R1", 3'd1, 8'h00);
    check("R1", 3'd2, 8'h00); check("R1", 3'd3, 8'h00);
    check("R1", 3'd4, 8'h01); check("R1", 3'd5, 8'h01);
    check("R1", 3'd6, 8'h01); check("R1", 3'd7, 8'h00);
    // R10 idle holds
    repeat (10) @(negedge clk_i);
    check("R10", 3'd0, 8'h00);
    // R2 ticks step hundredths
    ticks(5);
    check("R2", 3'd0, 8'h05);
    repeat (5) @(negedge clk_i);
    check("R10", 3'd0, 8'h05);
    // R3 write loads and clears hundredths
    wr(3'd1, 8'h42);
    check("R3", 3'd0, 8'h00);
    check("R3", 3'd1, 8'h42);
    // R3 write beats tick
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd2; wr_data_i = 8'h10;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R3", 3'd0, 8'h00);
    check("R3", 3'd2, 8'h10);
    // R2 hundredths carry into seconds
    ticks(100);
    check("R2", 3'd1, 8'h43);
    check("R2", 3'd0, 8'h00);

    for (int i = 0; i < 12; i++) begin
      wr(3'd3, VECS[i].hr);
      wr(3'd5, VECS[i].dt);
      wr(3'd6, VECS[i].mo);
      wr(3'd7, VECS[i].yr);
      wr(3'd4, VECS[i].dw);
      wr(3'd2, 8'h59);
      wr(3'd1, 8'h59);
      ticks(100);
      check("R2", 3'd1, 8'h00);
      check("R2", 3'd2, 8'h00);
      check("R4/R5 hour", 3'd3, VECS[i].hr_x);
      check("R6/R7 date", 3'd5, VECS[i].dt_x);
      check("R6/R9 month", 3'd6, VECS[i].mo_x);
      check("R9 year", 3'd7, VECS[i].yr_x);
      check("R8 dow", 3'd4, VECS[i].dw_x);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule